// File: doc/BRIEF.md
# Interleaved I/Q Input Demultiplexer

This block sits at the front of a transmit datapath. It receives one stream of words in which I and Q samples share the same bus, and splits it into separate I and Q outputs. A single `pair_valid` pulse marks each cycle in which a new, complete I/Q pair appears on those outputs. While transmit enable is low, no words are accepted and both outputs hold the offset-binary mid-scale code.

The block can tell I words from Q words in two ways, and one configuration bit chooses between them. In sequence mode, the first word after enable rises is an I word, and the words after it alternate Q, I, Q. In flag mode, a per-word Q indicator input says what each word is. The configuration bit is bit 3 of register 9, written through a small address, data and write-strobe port.

The block also holds a phase accumulator for an attached oscillator. It adds a frequency word on every cycle, and an active-high phase strobe clears it to zero. An active-low asynchronous reset clears every register.

Top module: `iq_demux`

## Requirements
- R1: After reset, `i_out` and `q_out` are 16'h8000, `pair_valid` is 0, `phase_acc` is 0 and sequence mode is selected.
- R2: In any cycle sampled with `tx_en` low, no word is accepted. At that edge `i_out` and `q_out` become 16'h8000 and `pair_valid` becomes 0.
- R3: In sequence mode, the word sampled at the first rising edge with `tx_en` high is taken as I, and `pair_valid` stays 0 after it.
- R4: In sequence mode, words alternate I then Q. At the edge that samples each Q word, `i_out` takes the preceding I word, `q_out` takes the Q word, and `pair_valid` pulses for one cycle. At every other enabled edge the outputs hold.
- R5: A low `tx_en` clears the alternation state. A word left waiting for its Q partner is discarded, and the next enabled word is again taken as I.
- R6: Writing 1 to bit 3 of register 9 (`cfg_addr`=9, `cfg_wdata[3]`=1, `cfg_we`=1) selects flag mode, and writing 0 there selects sequence mode. In flag mode, `q_flag`=0 marks the word as I and replaces any waiting I word. `q_flag`=1 marks it as Q and pairs it with the latest waiting I word.
- R7: In flag mode, a Q word that arrives while no I word is waiting is dropped. `pair_valid` stays 0 and the outputs hold.
- R8: A write to any address other than 9, or to bits of register 9 other than bit 3, has no effect on the framing mode.
- R9: While `phase_clr` is low, `phase_acc` increases by `freq_word` at every edge, wrapping modulo 2^32.
- R10: At any edge where `phase_clr` is high, `phase_acc` becomes 0.
- R11: `pair_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| tx_en | input | 1 | Transmit enable |
| q_flag | input | 1 | Marks the current word as Q in flag mode |
| din | input | 16 | Interleaved sample word |
| phase_clr | input | 1 | Clears the phase accumulator |
| freq_word | input | 32 | Phase increment per cycle |
| i_out | output | 16 | I sample of the latest pair |
| q_out | output | 16 | Q sample of the latest pair |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |
| phase_acc | output | 32 | Phase accumulator value |

## Verification
Some rules are checked by assertions on every cycle: the mid-scale outputs while disabled, the fact that no pair can complete on the first word after enable, the single-cycle valid pulse, the outputs holding between pairs, and the accumulator stepping and clearing. Other behaviour depends on word values and history, so only the directed scenarios can show it. These include which word lands on which output, the restart with I after a gap in enable, the replacement of a waiting I word and the dropping of an orphan Q word in flag mode, and the decoding of the mode bit.

// File: rtl/iq_demux.sv
module iq_demux #(
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 32,
  parameter int CFG_AW   = 4,
  parameter int CFG_DW   = 8,
  parameter int MODE_REG = 9,
  parameter int MODE_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  input  logic              tx_en,
  input  logic              q_flag,
  input  logic [DATA_W-1:0] din,
  input  logic              phase_clr,
  input  logic [ACC_W-1:0]  freq_word,
  output logic [DATA_W-1:0] i_out,
  output logic [DATA_W-1:0] q_out,
  output logic              pair_valid,
  output logic [ACC_W-1:0]  phase_acc
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(MODE_REG);

  logic              flag_mode;
  logic              pending;
  logic [DATA_W-1:0] i_hold;

  wire word_is_q = flag_mode ? q_flag : pending;
  wire take_pair = tx_en && word_is_q && pending;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      flag_mode <= 1'b0;
    else if (cfg_we && cfg_addr == MODE_ADDR)
      flag_mode <= cfg_wdata[MODE_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      i_hold     <= MID;
      pending    <= 1'b0;
      i_out      <= MID;
      q_out      <= MID;
      pair_valid <= 1'b0;
    end else if (!tx_en) begin
      pending    <= 1'b0;
      i_out      <= MID;
      q_out      <= MID;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= take_pair;
      if (!word_is_q) begin
        i_hold  <= din;
        pending <= 1'b1;
      end else if (pending) begin
        i_out   <= i_hold;
        q_out   <= din;
        pending <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         phase_acc <= '0;
    else if (phase_clr) phase_acc <= '0;
    else                phase_acc <= phase_acc + freq_word;
endmodule

module iq_demux_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              flag_mode,
  input logic              phase_clr,
  input logic [ACC_W-1:0]  freq_word,
  input logic [DATA_W-1:0] i_out,
  input logic [DATA_W-1:0] q_out,
  input logic              pair_valid,
  input logic [ACC_W-1:0]  phase_acc
);
  localparam logic [DATA_W-1:0] MID = {1'b1, {(DATA_W-1){1'b0}}};

  AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (i_out == MID && q_out == MID && !pair_valid)); // R2
  AST_FIRST_WORD_IS_I: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !$past(tx_en) && !flag_mode) |=> !pair_valid); // R3
  AST_HOLD_BETWEEN_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> (pair_valid || ($stable(i_out) && $stable(q_out)))); // R4
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid); // R11
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_clr |=> phase_acc == $past(phase_acc + freq_word)); // R9
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    phase_clr |=> phase_acc == '0); // R10
endmodule

bind iq_demux iq_demux_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .flag_mode(flag_mode),
  .phase_clr(phase_clr), .freq_word(freq_word), .i_out(i_out),
  .q_out(q_out), .pair_valid(pair_valid), .phase_acc(phase_acc)
);

// File: tb/iq_demux_bench.sv
module iq_demux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        tx_en = 1'b0;
  logic        q_flag = 1'b0;
  logic [15:0] din = '0;
  logic        phase_clr = 1'b1;
  logic [31:0] freq_word = '0;
  logic [15:0] i_out, q_out;
  logic        pair_valid;
  logic [31:0] phase_acc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  iq_demux u_iq_demux (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tx_en(tx_en), .q_flag(q_flag), .din(din),
    .phase_clr(phase_clr), .freq_word(freq_word), .i_out(i_out),
    .q_out(q_out), .pair_valid(pair_valid), .phase_acc(phase_acc)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, logic v, logic [15:0] i, logic [15:0] q);
    chk(req, {15'd0, pair_valid, i_out, q_out}, {15'd0, v, i, q});
  endtask

  task automatic word(logic en, logic qf, logic [15:0] d);
    tx_en = en; q_flag = qf; din = d;
    step();
  endtask

  task automatic cfg_write(logic [3:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    chk_out("R1", 1'b0, 16'h8000, 16'h8000);
    chk("R1", {16'd0, phase_acc}, 48'd0);
  endtask

  task automatic t_sequence();
    word(1, 0, 16'h1111); chk_out("R3", 1'b0, 16'h8000, 16'h8000);
    word(1, 1, 16'h2222); chk_out("R4", 1'b1, 16'h1111, 16'h2222);
    word(1, 0, 16'h3333); chk_out("R4 hold", 1'b0, 16'h1111, 16'h2222);
    word(1, 0, 16'h4444); chk_out("R4", 1'b1, 16'h3333, 16'h4444);
    word(1, 0, 16'h5555); chk_out("R11", 1'b0, 16'h3333, 16'h4444);
  endtask

  task automatic t_disable_restart();
    word(0, 0, 16'h6666); chk_out("R2", 1'b0, 16'h8000, 16'h8000);
    word(0, 0, 16'h7777); chk_out("R2", 1'b0, 16'h8000, 16'h8000);
    word(1, 0, 16'hAAAA); chk_out("R5", 1'b0, 16'h8000, 16'h8000);
    word(1, 0, 16'hBBBB); chk_out("R5", 1'b1, 16'hAAAA, 16'hBBBB);
    word(0, 0, 16'h0000);
  endtask

  task automatic t_flag_mode();
    cfg_write(4'd9, 8'h08);
    word(1, 1, 16'hC0C0); chk_out("R7", 1'b0, 16'h8000, 16'h8000);
    word(1, 0, 16'h0101); chk_out("R6", 1'b0, 16'h8000, 16'h8000);
    word(1, 0, 16'h0202); chk_out("R6", 1'b0, 16'h8000, 16'h8000);
    word(1, 1, 16'h0303); chk_out("R6", 1'b1, 16'h0202, 16'h0303);
    word(1, 1, 16'h0404); chk_out("R7", 1'b0, 16'h0202, 16'h0303);
    cfg_write(4'd8, 8'h00);
    cfg_write(4'd9, 8'hFF & ~8'h00);
    cfg_write(4'd1, 8'h00);
    word(1, 0, 16'h0505); chk_out("R8", 1'b0, 16'h0202, 16'h0303);
    word(1, 0, 16'h0606); chk_out("R8", 1'b0, 16'h0202, 16'h0303);
    word(1, 1, 16'h0707); chk_out("R8", 1'b1, 16'h0606, 16'h0707);
    word(0, 0, 16'h0000);
    cfg_write(4'd9, 8'hF7);
    word(1, 1, 16'h0808); chk_out("R6 seq", 1'b0, 16'h8000, 16'h8000);
    word(1, 1, 16'h0909); chk_out("R6 seq", 1'b1, 16'h0808, 16'h0909);
    word(0, 0, 16'h0000);
  endtask

  task automatic t_nco();
    freq_word = 32'd5; phase_clr = 1'b1; step();
    chk("R10", {16'd0, phase_acc}, 48'd0);
    phase_clr = 1'b0; step();
    chk("R9", {16'd0, phase_acc}, 48'd5);
    step();
    chk("R9", {16'd0, phase_acc}, 48'd10);
    freq_word = 32'hFFFF_FFFE; step();
    chk("R9 wrap", {16'd0, phase_acc}, 48'd8);
    phase_clr = 1'b1; step();
    chk("R10", {16'd0, phase_acc}, 48'd0);
    phase_clr = 1'b0;
  endtask

  initial begin
    #3 rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    #1;
    t_reset();
    phase_clr = 1'b0;
    step();
    t_sequence();
    t_disable_restart();
    t_flag_mode();
    t_nco();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule